// File: doc/BRIEF.md
# Logic-Cell Structural Test Data Register

This block is a user data register for a scan test port. It lets an external test access controller apply stimulus to a logic cell under test and read back the cell's responses, all through one serial data path. The controller supplies the serial input, a select, and capture, shift and update strobes. The block has no controller state machine and no instruction register of its own.

The serial path has two parts. A 13-bit vector stage sits nearest the serial input and has a shift part and a held, applied part. A 12-bit response stage sits nearest the serial output. Once a vector is updated, it drives two identical 6-output slices at the same time. A capture loads both slices' outputs into the response stage in one cycle. The next shift sequence then moves them out, and the same sequence moves the next vector in.

A combinational two-slice model stands in for the real cell. A complete test set is about forty vectors. Each vector costs one shift sequence, one update and one capture.

Top module: `lct_cell_test_reg`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, `vec_o` is all zero, `tdo` is 0, and both internal stages hold zero.
- R2: Each clock with `sel_i` and `shift_i` high performs one shift step. `tdi` enters vector bit 12. Every bit moves one place toward bit 0. Vector bit 0 enters response bit 11, and `tdo` always shows response bit 0. The path from `tdi` to `tdo` is 25 stages long.
- R3: `vec_o` changes only on a clock with `sel_i` and `update_i` high, and it then takes the content of the vector shift part. Shifting never moves `vec_o`.
- R4: Both slices receive `vec_o`. Output bit k of a slice is the XOR of the vector bits whose index modulo 6 equals k. So bit 0 is v0^v6^v12, bit 1 is v1^v7, and so on up to bit 5, which is v5^v11.
- R5: A clock with `sel_i` and `capture_i` high loads the response stage. Slice 0 goes to bits 5:0 and slice 1 to bits 11:6. Slice 0 bit 0 is visible on `tdo` right after that clock.
- R6: When capture and shift fall in the same clock, the response stage captures and does not shift. The vector stage still shifts.
- R7: When capture and update fall in the same clock, the response is taken from the vector applied before that clock, and `vec_o` takes the new vector.
- R8: While `sel_i` is low, all strobes and `tdi` are ignored. `vec_o`, `tdo` and both stages keep their contents.
- R9: The vector shift part holds its content on every selected clock that is not a shift step, including capture-only and update-only clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register selected by the controller |
| capture_i | input | 1 | Capture strobe, loads slice responses |
| shift_i | input | 1 | Shift strobe, advances the serial path |
| update_i | input | 1 | Update strobe, applies the shifted vector |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, response bit 0 |
| vec_o | output | 13 | Vector applied to both slices |

## Verification
Capture can coincide with either of the other strobes. When it coincides with shift, the bench applies a vector whose response differs from the value a shift would leave. It then checks that `tdo` shows the captured bit at once, and that a later update shows the vector stage advanced by one place. When capture coincides with update, the response stage is first cleared by shifting in zeros. The bench then checks that the response read out afterwards belongs to the old applied vector, and that `vec_o` now carries the new one.

// File: rtl/lct_pkg.sv
package lct_pkg;

   typedef struct packed {
      logic cap;
      logic shf;
      logic upd;
   } lct_op_t;

   function automatic lct_op_t lct_qualify(input logic sel,
                                           input logic cap,
                                           input logic shf,
                                           input logic upd);
      lct_op_t o;
      o.cap = sel & cap;
      o.shf = sel & shf;
      o.upd = sel & upd;
      return o;
   endfunction

endpackage

// File: rtl/lct_vec_stage.sv
module lct_vec_stage #(
   parameter int VEC_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tdi_i,
   input  logic             shift_i,
   input  logic             update_i,
   output logic             ser_o,
   output logic [VEC_W-1:0] vec_o
);

   logic [VEC_W-1:0] sh_q;
   logic [VEC_W-1:0] upd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (shift_i) begin
         sh_q <= {tdi_i, sh_q[VEC_W-1:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_q <= '0;
      end else if (update_i) begin
         upd_q <= sh_q;
      end
   end

   assign ser_o = sh_q[0];
   assign vec_o = upd_q;

   // R2: serial input lands in the top bit
   p_shift_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i |=> sh_q[VEC_W-1] == $past(tdi_i));

   // R9: shift part is frozen on any non-shift clock
   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_i |=> $stable(sh_q));

   // R3: applied vector moves only on update
   p_apply_only_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !update_i |=> $stable(upd_q));

   // R3/R7: update copies the pre-edge shift content
   p_update_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      update_i |=> upd_q == $past(sh_q));

endmodule

// File: rtl/lct_slice_model.sv
module lct_slice_model #(
   parameter int VEC_W = 13,
   parameter int OUT_W = 6
) (
   input  logic [VEC_W-1:0] vec_i,
   output logic [OUT_W-1:0] out_o
);

   function automatic logic [VEC_W-1:0] fold_mask(input int k);
      logic [VEC_W-1:0] m;
      for (int i = 0; i < VEC_W; i++) begin
         m[i] = ((i % OUT_W) == k);
      end
      return m;
   endfunction

   for (genvar k = 0; k < OUT_W; k++) begin : g_out
      localparam logic [VEC_W-1:0] MASK = fold_mask(k);
      assign out_o[k] = ^(vec_i & MASK);
   end

endmodule

// File: rtl/lct_resp_chain.sv
module lct_resp_chain #(
   parameter int RSP_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_i,
   input  logic             shift_i,
   input  logic             capture_i,
   input  logic [RSP_W-1:0] cap_data_i,
   output logic             tdo_o
);

   logic [RSP_W-1:0] rsp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_q <= '0;
      end else if (capture_i) begin
         rsp_q <= cap_data_i;
      end else if (shift_i) begin
         rsp_q <= {ser_i, rsp_q[RSP_W-1:1]};
      end
   end

   assign tdo_o = rsp_q[0];

   // R5: capture loads the parallel slice outputs
   p_capture_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      capture_i |=> rsp_q == $past(cap_data_i));

   // R6: capture wins over shift in the same clock
   p_cap_over_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (capture_i && shift_i) |=> tdo_o == $past(cap_data_i[0]));

   // R2: a pure shift feeds the top response bit from the vector stage
   p_shift_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && !capture_i) |=> rsp_q[RSP_W-1] == $past(ser_i));

endmodule

// File: rtl/lct_cell_test_reg.sv
module lct_cell_test_reg #(
   parameter int VEC_W   = 13,
   parameter int OUT_W   = 6,
   parameter int N_SLICE = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_i,
   input  logic             capture_i,
   input  logic             shift_i,
   input  logic             update_i,
   input  logic             tdi,
   output logic             tdo,
   output logic [VEC_W-1:0] vec_o
);

   localparam int RSP_W = N_SLICE * OUT_W;

   if (VEC_W < 2) begin : g_bad_vec
      $error("lct_cell_test_reg: VEC_W must be at least 2");
   end
   if (OUT_W < 1 || OUT_W > VEC_W) begin : g_bad_out
      $error("lct_cell_test_reg: OUT_W must lie in 1..VEC_W");
   end
   if (N_SLICE < 1 || RSP_W < 2) begin : g_bad_slice
      $error("lct_cell_test_reg: response stage needs at least 2 bits");
   end

   lct_pkg::lct_op_t op;
   logic             vec_ser;
   logic [RSP_W-1:0] cap_data;

   assign op = lct_pkg::lct_qualify(sel_i, capture_i, shift_i, update_i);

   lct_vec_stage #(.VEC_W(VEC_W)) u_vec (
      .clk      (clk),
      .rst_n    (rst_n),
      .tdi_i    (tdi),
      .shift_i  (op.shf),
      .update_i (op.upd),
      .ser_o    (vec_ser),
      .vec_o    (vec_o)
   );

   for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
      lct_slice_model #(.VEC_W(VEC_W), .OUT_W(OUT_W)) u_slice (
         .vec_i (vec_o),
         .out_o (cap_data[s*OUT_W +: OUT_W])
      );
   end

   lct_resp_chain #(.RSP_W(RSP_W)) u_rsp (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_i      (vec_ser),
      .shift_i    (op.shf),
      .capture_i  (op.cap),
      .cap_data_i (cap_data),
      .tdo_o      (tdo)
   );

   // R8: a deselected register keeps its visible state
   p_sel_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |=> ($stable(tdo) && $stable(vec_o)));

   // R1: outputs are cleared while reset is held
   always_comb begin
      if (!rst_n) begin
         p_reset_clear_r1: assert (vec_o == '0 && tdo == 1'b0);
      end
   end

endmodule

// File: tb/lct_cell_test_reg_tb.sv
`timescale 1ns/1ps
module lct_cell_test_reg_tb_top;

   localparam int VW = 13;
   localparam int RW = 12;
   localparam int PW = VW + RW;

   localparam logic [VW-1:0] VTAB [8] = '{
      13'h0000, 13'h1FFF, 13'h1555, 13'h0AAA,
      13'h1001, 13'h0040, 13'h1234, 13'h0F0F
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel = 1'b0, cap = 1'b0, shf = 1'b0, upd = 1'b0, tdi = 1'b0;
   logic tdo;
   logic [VW-1:0] vec_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lct_cell_test_reg dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (sel),
      .capture_i (cap),
      .shift_i   (shf),
      .update_i  (upd),
      .tdi       (tdi),
      .tdo       (tdo),
      .vec_o     (vec_o)
   );

   function automatic logic [5:0] ref_slice(input logic [VW-1:0] v);
      return {v[5]^v[11], v[4]^v[10], v[3]^v[9], v[2]^v[8], v[1]^v[7], v[0]^v[6]^v[12]};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_shift(input logic [PW-1:0] pat, output logic [PW-1:0] seen);
      for (int b = 0; b < PW; b++) begin
         @(negedge clk);
         seen[b] = tdo;
         sel = 1'b1; shf = 1'b1; tdi = pat[b];
      end
      @(negedge clk);
      shf = 1'b0; tdi = 1'b0;
   endtask

   task automatic pulse(input bit c, input bit s, input bit u, input bit d);
      @(negedge clk);
      sel = 1'b1; cap = c; shf = s; upd = u; tdi = d;
      @(negedge clk);
      cap = 1'b0; shf = 1'b0; upd = 1'b0; tdi = 1'b0;
   endtask

   task automatic chk_rsp(input logic [PW-1:0] seen, input logic [VW-1:0] v, input string req);
      chk(seen[5:0] == ref_slice(v), {req, " slice0"}, 32'(seen[5:0]), 32'(ref_slice(v)));
      chk(seen[11:6] == ref_slice(v), {req, " slice1"}, 32'(seen[11:6]), 32'(ref_slice(v)));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [PW-1:0] seen;
      logic [VW-1:0] held;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(vec_o == '0, "R1 vec_o in reset", 32'(vec_o), 0);
      chk(tdo == 1'b0, "R1 tdo in reset", 32'(tdo), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(vec_o == '0 && tdo == 1'b0, "R1 after release", 32'({vec_o, tdo}), 0);

      // Table walk: shift, update, capture; R2 R3 R4 R5
      for (int i = 0; i < 8; i++) begin
         held = vec_o;
         do_shift({VTAB[i], 12'b0}, seen);
         chk(vec_o == held, "R3 vec_o held during shift", 32'(vec_o), 32'(held));
         if (i > 0) begin
            chk_rsp(seen, VTAB[i-1], "R4");
            chk(seen[PW-1:RW] == VTAB[i-1], "R2 old vector out via tdo", 32'(seen[PW-1:RW]), 32'(VTAB[i-1]));
         end
         pulse(1'b0, 1'b0, 1'b1, 1'b0);
         chk(vec_o == VTAB[i], "R3 update applies vector", 32'(vec_o), 32'(VTAB[i]));
         pulse(1'b1, 1'b0, 1'b0, 1'b0);
         chk(tdo == ref_slice(VTAB[i])[0], "R5 tdo after capture", 32'(tdo), 32'(ref_slice(VTAB[i])[0]));
      end

      // R8: strobes ignored while deselected
      do_shift({13'h1234, 12'b0}, seen);
      chk_rsp(seen, VTAB[7], "R4 last table entry");
      pulse(1'b0, 1'b0, 1'b1, 1'b0);
      pulse(1'b1, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      sel = 1'b0; cap = 1'b1; shf = 1'b1; upd = 1'b1; tdi = 1'b1;
      repeat (5) @(negedge clk);
      cap = 1'b0; shf = 1'b0; upd = 1'b0; tdi = 1'b0;
      chk(vec_o == 13'h1234, "R8 vec_o unchanged", 32'(vec_o), 32'h1234);
      chk(tdo == ref_slice(13'h1234)[0], "R8 tdo unchanged", 32'(tdo), 32'(ref_slice(13'h1234)[0]));
      do_shift({13'h0AAA, 12'b0}, seen);
      chk_rsp(seen, 13'h1234, "R8 response kept");
      chk(seen[PW-1:RW] == 13'h1234, "R8 shift part kept", 32'(seen[PW-1:RW]), 32'h1234);

      // R7: capture and update in one clock
      pulse(1'b1, 1'b0, 1'b1, 1'b0);
      chk(vec_o == 13'h0AAA, "R7 new vector applied", 32'(vec_o), 32'h0AAA);
      chk(tdo == ref_slice(13'h1234)[0], "R7 tdo from old vector", 32'(tdo), 32'(ref_slice(13'h1234)[0]));
      do_shift({13'h1555, 12'b0}, seen);
      chk_rsp(seen, 13'h1234, "R7 response of old vector");

      // R6: capture and shift in one clock
      pulse(1'b0, 1'b0, 1'b1, 1'b0);
      chk(vec_o == 13'h1555, "R3 update", 32'(vec_o), 32'h1555);
      pulse(1'b1, 1'b1, 1'b0, 1'b1);
      chk(tdo == ref_slice(13'h1555)[0], "R6 capture wins on tdo", 32'(tdo), 32'(ref_slice(13'h1555)[0]));
      chk(vec_o == 13'h1555, "R3 vec_o held", 32'(vec_o), 32'h1555);
      pulse(1'b0, 1'b0, 1'b1, 1'b0);
      chk(vec_o == {1'b1, 12'hAAA}, "R6 vector stage still shifted", 32'(vec_o), 32'h1AAA);

      // R9: capture-only clock leaves shift part alone
      pulse(1'b1, 1'b0, 1'b0, 1'b0);
      pulse(1'b0, 1'b0, 1'b1, 1'b0);
      chk(vec_o == 13'h1AAA, "R9 shift part kept over capture", 32'(vec_o), 32'h1AAA);
      do_shift({PW{1'b0}}, seen);
      chk_rsp(seen, 13'h1AAA, "R6 R9 response read back");
      chk(seen[PW-1:RW] == 13'h1AAA, "R9 shift part content", 32'(seen[PW-1:RW]), 32'h1AAA);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule